// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of recent virtual-to-physical page translations so that a processor pipeline can translate an address in the same cycle it is presented. Each resident translation is tagged with the identifier of the address space that owns it. A lookup compares the virtual page number and the current address-space identifier against every slot at once. The page offset bypasses translation and is appended unchanged to the physical page number. Each slot also keeps three access-right bits. A match whose rights do not cover the requested kind of access is reported as a protection fault, not as a hit.

When a lookup misses, an external page walker supplies the translation through the refill port. The slot that receives it is chosen in a fixed order. A slot already holding the same page and identifier is reused first. Otherwise the lowest-numbered empty slot is used. When the table is full, a free-running pseudo-random sequence picks the victim. A flush request empties the whole table, or only the slots of one address space. The walker only ever sends valid translations, so every occupied slot is a usable mapping.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss.
- R2: A lookup whose page number and identifier match an occupied slot with sufficient rights raises hit in the same cycle. The physical address output is then the slot's physical page number in the upper bits and the lookup's page offset, unchanged, in the low 12 bits.
- R3: Matching requires the identifier as well as the page number. The same virtual page may be resident under several identifiers at once, each translating to its own physical page.
- R4: The rights bits are bit 0 read, bit 1 write and bit 2 execute. The access kind is 0 load, 1 store, 2 instruction fetch and 3 reserved; reserved is never permitted. A match without the needed right raises fault only, and the physical address output is zero whenever hit is low.
- R5: At most one of hit, miss and fault is high. All three are low while no lookup is requested.
- R6: A refill takes effect at the next clock edge and is visible to lookups from then on. Slots become occupied only through refills.
- R7: A refill whose page number and identifier are already resident overwrites that slot's physical page and rights and creates no second copy.
- R8: While any slot is empty, a refill of a new mapping goes into an empty slot and evicts nothing.
- R9: When the table is full, a refill of a new mapping evicts exactly one resident mapping, chosen pseudo-randomly. The table stays full.
- R10: A full flush empties every slot at the next clock edge.
- R11: A flush by identifier empties only the slots carrying that identifier. All other mappings stay resident.
- R12: A flush and a refill in the same cycle: the flush is applied and the refill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup requested this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_offset | input | 12 | Page offset, passed through unchanged |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No resident translation |
| lk_fault | output | 1 | Translation found but access not permitted |
| lk_paddr | output | 32 | Physical address on hit, zero otherwise |
| rf_valid | input | 1 | Install a translation at the next edge |
| rf_vpn | input | 20 | Virtual page number of the new translation |
| rf_asid | input | 8 | Identifier of the new translation |
| rf_ppn | input | 20 | Physical page number of the new translation |
| rf_perm | input | 3 | Rights of the new translation: bit 0 read, bit 1 write, bit 2 execute |
| fl_valid | input | 1 | Flush requested |
| fl_by_asid | input | 1 | Flush only slots whose identifier equals fl_asid |
| fl_asid | input | 8 | Identifier selected for a partial flush |

## Verification
The bound checker watches the lookup result encoding on every cycle: the three outcomes are mutually exclusive, all of them are silent when no lookup is requested, and the address is zero unless hit is high. It also tracks the occupancy vector across edges. A full flush empties the table, a flush never adds a slot, a refill adds at most one, occupancy never grows without a refill, and a full table stays full under refill. Which mapping is translated, kept or evicted can only be shown by the bench's scenarios, which probe the lookup port. These cover identifier separation, the rights table per access kind, overwrite of a resident duplicate, use of empty slots before eviction, exactly-one eviction over several rounds on a full table, and partial flush.

// File: rtl/xlat_pkg.sv
// Shared encodings for the translation cache: access kinds, rights-bit
// positions and the permission decision. Assumes three rights bits.
package xlat_pkg;

    localparam int PERM_W = 3;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // Decide whether a rights field allows a given access kind.
    function automatic logic access_ok(input logic [PERM_W-1:0] perm,
                                       input logic [1:0] kind);
        logic ok;
        case (acc_kind_e'(kind))
            ACC_LOAD:  ok = perm[PERM_RD];
            ACC_STORE: ok = perm[PERM_WR];
            ACC_FETCH: ok = perm[PERM_EX];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_match.sv
// Parallel tag comparator: one comparator per slot checks occupancy, page
// number and identifier against a key. Purely combinational. Assumes the
// caller keeps at most one occupied slot per page/identifier pair.
module xlat_match #(
    parameter int unsigned N      = 16,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned ASID_W = 8
) (
    input  logic [N-1:0]      valid_i,
    input  logic [VPN_W-1:0]  vpn_i  [N],
    input  logic [ASID_W-1:0] asid_i [N],
    input  logic [VPN_W-1:0]  key_vpn_i,
    input  logic [ASID_W-1:0] key_asid_i,
    output logic [N-1:0]      match_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Compare one slot's tag with the key.
        assign match_o[g] = valid_i[g]
                          && (vpn_i[g] == key_vpn_i)
                          && (asid_i[g] == key_asid_i);
    end

endmodule

// File: rtl/xlat_victim.sv
// Refill slot selection. Priority: the slot already holding the same tag,
// then the lowest-numbered empty slot, then a pseudo-random slot.
// The random source is a de Bruijn-extended LFSR that walks all 2**IDX_W
// states, so every slot can be picked. Assumes N == 2**IDX_W and IDX_W >= 2,
// and that TAPS is a maximal-length tap set for IDX_W.
module xlat_victim #(
    parameter int unsigned   N     = 16,
    parameter int unsigned   IDX_W = 4,
    parameter logic [IDX_W-1:0] TAPS = 4'b1001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_i,
    input  logic [N-1:0]     dup_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] rnd_q;
    logic             rnd_fb;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] dup_idx;
    logic             any_free;
    logic             any_dup;

    // Feedback bit, with the all-low-bits term that adds the zero state.
    assign rnd_fb = (^(rnd_q & TAPS)) ^ (rnd_q[IDX_W-2:0] == '0);

    // Free-running sequence, advancing every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd_q <= IDX_W'(1);
        else        rnd_q <= {rnd_q[IDX_W-2:0], rnd_fb};
    end

    // Lowest empty slot and index of a resident duplicate.
    always_comb begin
        free_idx = '0;
        dup_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
            if (dup_i[i])    dup_idx  = IDX_W'(i);
        end
    end

    assign any_free = ~&valid_i;
    assign any_dup  = |dup_i;

    // Apply the selection priority.
    always_comb begin
        if (any_dup)       idx_o = dup_idx;
        else if (any_free) idx_o = free_idx;
        else               idx_o = rnd_q;
    end

endmodule

// File: rtl/xlat_store.sv
// Slot storage: occupancy bit, tag, physical page and rights per slot.
// Flushes act at the clock edge and take precedence over a write to the
// same slot; the top only asserts wr_en_i when no flush is requested.
module xlat_store #(
    parameter int unsigned N      = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PPN_W  = 20,
    parameter int unsigned ASID_W = 8,
    parameter int unsigned PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [VPN_W-1:0]  wr_vpn_i,
    input  logic [ASID_W-1:0] wr_asid_i,
    input  logic [PPN_W-1:0]  wr_ppn_i,
    input  logic [PERM_W-1:0] wr_perm_i,
    input  logic              fl_all_i,
    input  logic              fl_sel_i,
    input  logic [ASID_W-1:0] fl_asid_i,
    output logic [N-1:0]      valid_o,
    output logic [VPN_W-1:0]  vpn_o  [N],
    output logic [ASID_W-1:0] asid_o [N],
    output logic [PPN_W-1:0]  ppn_o  [N],
    output logic [PERM_W-1:0] perm_o [N]
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic wr_here;
        logic kill_here;

        assign wr_here   = wr_en_i && (wr_idx_i == IDX_W'(g));
        assign kill_here = fl_all_i || (fl_sel_i && (asid_o[g] == fl_asid_i));

        // Occupancy: cleared by reset or flush, set by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)         valid_o[g] <= 1'b0;
            else if (kill_here) valid_o[g] <= 1'b0;
            else if (wr_here)   valid_o[g] <= 1'b1;
        end

        // Payload: loaded on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_o[g]  <= '0;
                asid_o[g] <= '0;
                ppn_o[g]  <= '0;
                perm_o[g] <= '0;
            end else if (wr_here) begin
                vpn_o[g]  <= wr_vpn_i;
                asid_o[g] <= wr_asid_i;
                ppn_o[g]  <= wr_ppn_i;
                perm_o[g] <= wr_perm_i;
            end
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
// Top of the identifier-tagged translation cache. Lookup is combinational
// against all slots; refill and flush act at the clock edge, flush first.
// Assumes N is a power of two of at least 4 and that the refill source
// never presents an invalid translation.
module xlat_tlb #(
    parameter int unsigned N        = 16,
    parameter int unsigned VPN_W    = 20,
    parameter int unsigned PPN_W    = 20,
    parameter int unsigned ASID_W   = 8,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned RND_TAPS = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VPN_W-1:0]        lk_vpn,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic [1:0]              lk_kind,
    input  logic [OFF_W-1:0]        lk_offset,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic                    lk_fault,
    output logic [PPN_W+OFF_W-1:0]  lk_paddr,
    input  logic                    rf_valid,
    input  logic [VPN_W-1:0]        rf_vpn,
    input  logic [ASID_W-1:0]       rf_asid,
    input  logic [PPN_W-1:0]        rf_ppn,
    input  logic [2:0]              rf_perm,
    input  logic                    fl_valid,
    input  logic                    fl_by_asid,
    input  logic [ASID_W-1:0]       fl_asid
);

    import xlat_pkg::*;

    localparam int unsigned IDX_W = $clog2(N);
    localparam int unsigned PA_W  = PPN_W + OFF_W;

    logic [N-1:0]      ent_valid;
    logic [VPN_W-1:0]  ent_vpn  [N];
    logic [ASID_W-1:0] ent_asid [N];
    logic [PPN_W-1:0]  ent_ppn  [N];
    logic [PERM_W-1:0] ent_perm [N];

    logic [N-1:0]      lk_match;
    logic [N-1:0]      rf_match;
    logic [IDX_W-1:0]  rf_idx;
    logic              rf_take;
    logic              fl_all;
    logic              fl_sel;
    logic [PPN_W-1:0]  sel_ppn;
    logic [PERM_W-1:0] sel_perm;
    logic              found;
    logic              allowed;

    // Flush wins over refill in the same cycle.
    assign rf_take = rf_valid && !fl_valid;
    assign fl_all  = fl_valid && !fl_by_asid;
    assign fl_sel  = fl_valid && fl_by_asid;

    xlat_store #(
        .N(N), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .ASID_W(ASID_W), .PERM_W(PERM_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(rf_take), .wr_idx_i(rf_idx),
        .wr_vpn_i(rf_vpn), .wr_asid_i(rf_asid),
        .wr_ppn_i(rf_ppn), .wr_perm_i(rf_perm),
        .fl_all_i(fl_all), .fl_sel_i(fl_sel), .fl_asid_i(fl_asid),
        .valid_o(ent_valid), .vpn_o(ent_vpn), .asid_o(ent_asid),
        .ppn_o(ent_ppn), .perm_o(ent_perm)
    );

    xlat_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .valid_i(ent_valid), .vpn_i(ent_vpn), .asid_i(ent_asid),
        .key_vpn_i(lk_vpn), .key_asid_i(lk_asid), .match_o(lk_match)
    );

    xlat_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
        .valid_i(ent_valid), .vpn_i(ent_vpn), .asid_i(ent_asid),
        .key_vpn_i(rf_vpn), .key_asid_i(rf_asid), .match_o(rf_match)
    );

    xlat_victim #(.N(N), .IDX_W(IDX_W), .TAPS(IDX_W'(RND_TAPS))) u_victim (
        .clk(clk), .rst_n(rst_n),
        .valid_i(ent_valid), .dup_i(rf_match), .idx_o(rf_idx)
    );

    // One-hot select of the matching slot's page and rights.
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                sel_ppn  = sel_ppn  | ent_ppn[i];
                sel_perm = sel_perm | ent_perm[i];
            end
        end
    end

    assign found   = |lk_match;
    assign allowed = access_ok(sel_perm, lk_kind);

    // Classify the lookup and form the physical address.
    always_comb begin
        lk_hit   = lk_valid && found && allowed;
        lk_fault = lk_valid && found && !allowed;
        lk_miss  = lk_valid && !found;
        lk_paddr = lk_hit ? {sel_ppn, lk_offset} : PA_W'(0);
    end

endmodule

// File: rtl/xlat_tlb_chk.sv
// Cycle-level checker for the translation cache, attached by bind. Watches
// the result encoding and the occupancy vector across edges.
module xlat_tlb_chk #(
    parameter int unsigned N    = 16,
    parameter int unsigned PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_hit,
    input logic            lk_miss,
    input logic            lk_fault,
    input logic [PA_W-1:0] lk_paddr,
    input logic            rf_valid,
    input logic            fl_valid,
    input logic            fl_by_asid,
    input logic [N-1:0]    occ
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault})); // R5

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R5

    AST_ADDR_ZERO_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0)); // R4

    AST_FULL_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_by_asid) |=> (occ == '0)); // R10

    AST_FLUSH_ADDS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |=> ($countones(occ) <= $countones($past(occ)))); // R12

    AST_REFILL_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !fl_valid) |=>
            ((occ != '0) && ($countones(occ) <= $countones($past(occ)) + 1))); // R6

    AST_NO_SPONTANEOUS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_valid |=> ($countones(occ) <= $countones($past(occ)))); // R6

    AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !fl_valid && (&occ)) |=> (&occ)); // R9

endmodule

bind xlat_tlb xlat_tlb_chk #(.N(N), .PA_W(PPN_W + OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .fl_valid(fl_valid), .fl_by_asid(fl_by_asid),
    .occ(ent_valid)
);

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_kind = '0;
    logic [11:0] lk_offset = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_ppn = '0;
    logic [2:0]  rf_perm = '0;
    logic        fl_valid = 1'b0;
    logic        fl_by_asid = 1'b0;
    logic [7:0]  fl_asid = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [19:0] res_vpn [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_tlb u_xlat_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_kind(lk_kind), .lk_offset(lk_offset),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rf_ppn(rf_ppn), .rf_perm(rf_perm),
        .fl_valid(fl_valid), .fl_by_asid(fl_by_asid), .fl_asid(fl_asid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic refill(input logic [19:0] v, input logic [7:0] a,
                          input logic [19:0] p, input logic [2:0] r);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = v; rf_asid = a; rf_ppn = p; rf_perm = r;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic flush(input logic by, input logic [7:0] a);
        @(negedge clk);
        fl_valid = 1'b1; fl_by_asid = by; fl_asid = a;
        @(negedge clk);
        fl_valid = 1'b0; fl_by_asid = 1'b0;
    endtask

    task automatic probe(input logic [19:0] v, input logic [7:0] a,
                         input logic [1:0] k, input logic [11:0] o);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_kind = k; lk_offset = o;
        #1;
    endtask

    // Result triple {hit, miss, fault} as a 3-bit value.
    function automatic logic [2:0] res();
        return {lk_hit, lk_miss, lk_fault};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        lk_valid = 1'b0; #1;
        chk("R5 idle outputs", {61'd0, res()}, 64'd0);
        probe(20'h00000, 8'h00, 2'd0, 12'h000);
        chk("R1 empty after reset", {61'd0, res()}, 64'b010);
        probe(20'h12345, 8'h03, 2'd0, 12'h000);
        chk("R1 empty after reset", {61'd0, res()}, 64'b010);
    endtask

    task automatic t_hit();
        refill(20'h12345, 8'h03, 20'hABCDE, 3'b111);
        probe(20'h12345, 8'h03, 2'd0, 12'h5A5);
        chk("R2 hit flags", {61'd0, res()}, 64'b100);
        chk("R2 paddr", {32'd0, lk_paddr}, {32'd0, 20'hABCDE, 12'h5A5});
        probe(20'h12345, 8'h03, 2'd2, 12'hFFF);
        chk("R6 visible after edge", {32'd0, lk_paddr}, {32'd0, 20'hABCDE, 12'hFFF});
    endtask

    task automatic t_asid();
        refill(20'h12345, 8'h04, 20'h11111, 3'b111);
        probe(20'h12345, 8'h03, 2'd0, 12'h001);
        chk("R3 first asid", {32'd0, lk_paddr}, {32'd0, 20'hABCDE, 12'h001});
        probe(20'h12345, 8'h04, 2'd0, 12'h001);
        chk("R3 second asid", {32'd0, lk_paddr}, {32'd0, 20'h11111, 12'h001});
        probe(20'h12345, 8'h05, 2'd0, 12'h001);
        chk("R3 foreign asid misses", {61'd0, res()}, 64'b010);
    endtask

    task automatic t_perm();
        refill(20'h00200, 8'h01, 20'h00777, 3'b001);
        probe(20'h00200, 8'h01, 2'd0, 12'h010);
        chk("R4 read-only load", {61'd0, res()}, 64'b100);
        probe(20'h00200, 8'h01, 2'd1, 12'h010);
        chk("R4 read-only store", {61'd0, res()}, 64'b001);
        chk("R4 fault paddr zero", {32'd0, lk_paddr}, 64'd0);
        probe(20'h00200, 8'h01, 2'd2, 12'h010);
        chk("R4 read-only fetch", {61'd0, res()}, 64'b001);
        refill(20'h00201, 8'h01, 20'h00778, 3'b110);
        probe(20'h00201, 8'h01, 2'd0, 12'h010);
        chk("R4 no-read load", {61'd0, res()}, 64'b001);
        probe(20'h00201, 8'h01, 2'd1, 12'h010);
        chk("R4 write store", {61'd0, res()}, 64'b100);
        probe(20'h00201, 8'h01, 2'd2, 12'h010);
        chk("R4 exec fetch", {61'd0, res()}, 64'b100);
        probe(20'h00201, 8'h01, 2'd3, 12'h010);
        chk("R4 reserved kind", {61'd0, res()}, 64'b001);
    endtask

    task automatic t_dup_and_free();
        int lost;
        flush(1'b0, 8'h00);
        refill(20'h00300, 8'h02, 20'h00001, 3'b111);
        refill(20'h00300, 8'h02, 20'h00002, 3'b001);
        probe(20'h00300, 8'h02, 2'd0, 12'h000);
        chk("R7 overwritten page", {32'd0, lk_paddr}, {32'd0, 20'h00002, 12'h000});
        probe(20'h00300, 8'h02, 2'd1, 12'h000);
        chk("R7 overwritten rights", {61'd0, res()}, 64'b001);
        for (int i = 0; i < 15; i++)
            refill(20'h00400 + 20'(i), (i < 5) ? 8'h07 : 8'h08, 20'h00900 + 20'(i), 3'b111);
        lost = 0;
        for (int i = 0; i < 15; i++) begin
            probe(20'h00400 + 20'(i), (i < 5) ? 8'h07 : 8'h08, 2'd0, 12'h000);
            if (!lk_hit) lost++;
        end
        probe(20'h00300, 8'h02, 2'd0, 12'h000);
        if (!lk_hit) lost++;
        chk("R7 no duplicate slot used", 64'(lost), 64'd0);

        flush(1'b1, 8'h07);
        lost = 0;
        for (int i = 0; i < 5; i++) begin
            probe(20'h00400 + 20'(i), 8'h07, 2'd0, 12'h000);
            if (!lk_miss) lost++;
        end
        chk("R11 selected asid flushed", 64'(lost), 64'd0);
        lost = 0;
        for (int i = 5; i < 15; i++) begin
            probe(20'h00400 + 20'(i), 8'h08, 2'd0, 12'h000);
            if (!lk_hit) lost++;
        end
        probe(20'h00300, 8'h02, 2'd0, 12'h000);
        if (!lk_hit) lost++;
        chk("R11 other asids kept", 64'(lost), 64'd0);

        for (int i = 0; i < 5; i++)
            refill(20'h00500 + 20'(i), 8'h06, 20'h00A00 + 20'(i), 3'b111);
        lost = 0;
        for (int i = 5; i < 15; i++) begin
            probe(20'h00400 + 20'(i), 8'h08, 2'd0, 12'h000);
            if (!lk_hit) lost++;
        end
        for (int i = 0; i < 5; i++) begin
            probe(20'h00500 + 20'(i), 8'h06, 2'd0, 12'h000);
            if (!lk_hit) lost++;
        end
        probe(20'h00300, 8'h02, 2'd0, 12'h000);
        if (!lk_hit) lost++;
        chk("R8 empty slots used first", 64'(lost), 64'd0);
    endtask

    task automatic t_random();
        int lost;
        int gone;
        flush(1'b0, 8'h00);
        for (int i = 0; i < 16; i++) begin
            res_vpn[i] = 20'h00600 + 20'(i);
            refill(res_vpn[i], 8'h05, 20'h00B00 + 20'(i), 3'b111);
        end
        for (int r = 0; r < 4; r++) begin
            refill(20'h00700 + 20'(r), 8'h05, 20'h00C00 + 20'(r), 3'b111);
            probe(20'h00700 + 20'(r), 8'h05, 2'd0, 12'h000);
            chk("R9 new mapping resident", {61'd0, res()}, 64'b100);
            lost = 0;
            gone = 0;
            for (int i = 0; i < 16; i++) begin
                probe(res_vpn[i], 8'h05, 2'd0, 12'h000);
                if (!lk_hit) begin
                    lost++;
                    gone = i;
                end
            end
            chk("R9 exactly one evicted", 64'(lost), 64'd1);
            res_vpn[gone] = 20'h00700 + 20'(r);
        end
    endtask

    task automatic t_flush();
        int lost;
        flush(1'b0, 8'h00);
        lost = 0;
        for (int i = 0; i < 16; i++) begin
            probe(res_vpn[i], 8'h05, 2'd0, 12'h000);
            if (!lk_miss) lost++;
        end
        chk("R10 full flush empties", 64'(lost), 64'd0);

        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = 20'h00800; rf_asid = 8'h09; rf_ppn = 20'h1; rf_perm = 3'b111;
        fl_valid = 1'b1; fl_by_asid = 1'b0;
        @(negedge clk);
        rf_valid = 1'b0; fl_valid = 1'b0;
        probe(20'h00800, 8'h09, 2'd0, 12'h000);
        chk("R12 refill dropped on full flush", {61'd0, res()}, 64'b010);

        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = 20'h00801; rf_asid = 8'h09; rf_ppn = 20'h2; rf_perm = 3'b111;
        fl_valid = 1'b1; fl_by_asid = 1'b1; fl_asid = 8'h0A;
        @(negedge clk);
        rf_valid = 1'b0; fl_valid = 1'b0; fl_by_asid = 1'b0;
        probe(20'h00801, 8'h09, 2'd0, 12'h000);
        chk("R12 refill dropped on partial flush", {61'd0, res()}, 64'b010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_asid();
        t_perm();
        t_dup_and_free();
        t_random();
        t_flush();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule